// File: doc/BRIEF.md
# DRAM Power-Up Initialisation Sequencer

This block brings an SDRAM, DDR1 or DDR2 memory controller out of reset. It does this by writing to the controller's registers in a fixed order, one write at a time. Each write is a one-cycle strobe that carries an address and a data word. After each write the block holds off for a time given in microseconds, which a cycle counter measures. The memory kind and the CAS latency are sampled when a start pulse arrives. They decide which steps run and which mode words are sent. Neither the controller datapath nor the DRAM is part of this block.

The sequence has six stages. The two configuration words are written, and the second is rewritten with its clock-enable bit set. All banks are precharged twice. On DDR2 parts the EMR2 and EMR3 loads follow. On DDR parts the extended mode register is loaded to enable the DLL. A mode-register setup with a long settle time comes next, followed by refresh cycles and the final mode load. DDR2 parts then receive two more extended mode loads. The last write is the refresh interval, with its enable bit set. While the sequence runs, `busy` is high. `done` pulses once when it finishes.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset, `busy`, `done` and `reg_we` are low, and they stay low until `start` is sampled high.
- R2: When `start` is sampled high while idle, the first write appears in the next cycle. `busy` stays high until the wait after the refresh write has expired. `done` is then high for exactly one cycle, with `busy` low, and the block returns to idle. `start` has no effect while `busy` is high.
- R3: Every write is a one-cycle `reg_we` strobe. The next write, or `done`, follows after 1 + W cycles, where W = microseconds × CLKS_PER_US. Control-register commands wait CMD_US (10). Configuration, extended mode, final mode and refresh writes wait REG_US (100). The initial mode word waits MODE_US (1000).
- R4: The sequence opens in this order: CFG_WORD to ADDR_CFG, CFG2_WORD to ADDR_CFG2, CFG2_WORD | 0x80 (clock enable) to ADDR_CFG2, then control code 0x08 (precharge all) twice to ADDR_CTRL.
- R5: Only for `mem_type` = 2 (DDR2), control codes 0x10 (EMR2) and 0x20 (EMR3) follow the precharges, in that order.
- R6: For every `mem_type` other than 0 (SDRAM), EXT_DLL_WORD is written to ADDR_EXT, followed by control code 0x02 (extended mode load). `mem_type` = 3 is treated as DDR1 (encodings: 0 SDRAM, 1 DDR1, 2 DDR2).
- R7: The final mode word is 0x43 when `cas_lat` = 4 and 0x33 for any other value. The initial mode word is the final word | 0x100. The mode stage is: initial word to ADDR_MODE, code 0x01, 0x08, 0x08, 0x04, 0x04, final word to ADDR_MODE, then code 0x01.
- R8: Only for DDR2, EXT_OCD_WORD is written to ADDR_EXT, then code 0x02, then EXT_FINAL_WORD to ADDR_EXT, then code 0x02.
- R9: The last write goes to ADDR_REF with the value 0x4000 | floor(CLKS_PER_US × 78125 / 10000). That value is the 7.8125 µs refresh interval in cycles, for example 625 at 80 cycles per µs.
- R10: `mem_type` and `cas_lat` are captured when the sequence starts. Changing them while `busy` is high does not alter the sequence already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins the sequence when the block is idle |
| mem_type | input | 2 | Memory kind: 0 SDRAM, 1 DDR1, 2 DDR2, 3 DDR1 |
| cas_lat | input | 3 | CAS latency; 4 selects 0x43, anything else 0x33 |
| busy | output | 1 | High while the sequence runs |
| done | output | 1 | One-cycle pulse at completion |
| reg_we | output | 1 | Register write strobe |
| reg_addr | output | ADDR_W | Register address of the current write |
| reg_wdata | output | DATA_W | Data of the current write |

## Verification
The bench builds the block with CLKS_PER_US = 2 and keeps the other parameters at their defaults. At that setting the 1000 µs settle time is 2000 cycles, so a whole sequence is a few thousand cycles. This lets every memory kind and both CAS choices run end to end, and lets each wait length be checked cycle by cycle against a separately built list of expected writes. The refresh field comes out at 15 with this setting. Two runs change the kind and latency inputs and re-pulse `start` in the middle of a sequence, so that they reach R10 and the ignored-start case.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

   // memory kind as presented on mem_type
   typedef enum logic [1:0] {
      MEM_SDR  = 2'd0,
      MEM_DDR1 = 2'd1,
      MEM_DDR2 = 2'd2,
      MEM_ALT  = 2'd3
   } mem_kind_t;

   // wait length class attached to every step
   typedef enum logic [1:0] {
      WC_CMD  = 2'd0,
      WC_REG  = 2'd1,
      WC_MODE = 2'd2
   } wait_cls_t;

   // which memory kinds run a step
   typedef enum logic [1:0] {
      GRP_ALL  = 2'd0,
      GRP_DDR2 = 2'd1,
      GRP_DLL  = 2'd2
   } grp_t;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ISSUE = 2'd1,
      SQ_WAIT  = 2'd2,
      SQ_FIN   = 2'd3
   } seq_state_t;

   // ordered step list; the order is the behaviour
   typedef enum logic [4:0] {
      ST_CFG      = 5'd0,
      ST_CFG2     = 5'd1,
      ST_CKE      = 5'd2,
      ST_PRE_A    = 5'd3,
      ST_PRE_B    = 5'd4,
      ST_EMR2     = 5'd5,
      ST_EMR3     = 5'd6,
      ST_DLL_WORD = 5'd7,
      ST_DLL_LOAD = 5'd8,
      ST_MODE_INI = 5'd9,
      ST_MR_A     = 5'd10,
      ST_PRE_C    = 5'd11,
      ST_PRE_D    = 5'd12,
      ST_AREF_A   = 5'd13,
      ST_AREF_B   = 5'd14,
      ST_MODE_FIN = 5'd15,
      ST_MR_B     = 5'd16,
      ST_OCD_WORD = 5'd17,
      ST_OCD_LOAD = 5'd18,
      ST_EXT_WORD = 5'd19,
      ST_EXT_LOAD = 5'd20,
      ST_REFRESH  = 5'd21
   } step_t;

   localparam int NUM_STEPS = 22;

   // control register command codes
   localparam logic [7:0] CMD_MR   = 8'h01;
   localparam logic [7:0] CMD_EMR  = 8'h02;
   localparam logic [7:0] CMD_AREF = 8'h04;
   localparam logic [7:0] CMD_PALL = 8'h08;
   localparam logic [7:0] CMD_EMR2 = 8'h10;
   localparam logic [7:0] CMD_EMR3 = 8'h20;

   localparam logic [15:0] CKE_BIT     = 16'h0080;
   localparam logic [15:0] REF_EN_BIT  = 16'h4000;
   localparam logic [15:0] MODE_INI_OR = 16'h0100;

   function automatic grp_t step_group(input step_t s);
      case (s)
         ST_EMR2, ST_EMR3,
         ST_OCD_WORD, ST_OCD_LOAD,
         ST_EXT_WORD, ST_EXT_LOAD:  return GRP_DDR2;
         ST_DLL_WORD, ST_DLL_LOAD:  return GRP_DLL;
         default:                   return GRP_ALL;
      endcase
   endfunction

   function automatic logic step_enabled(input step_t s, input mem_kind_t k);
      case (step_group(s))
         GRP_DDR2: return (k == MEM_DDR2);
         GRP_DLL:  return (k != MEM_SDR);
         default:  return 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/ddr_init_step_rom.sv
module ddr_init_step_rom
   import ddr_init_pkg::*;
#(
   parameter int          ADDR_W         = 8,
   parameter int          DATA_W         = 32,
   parameter int          CLKS_PER_US    = 250,
   parameter logic [7:0]  ADDR_CFG       = 8'h00,
   parameter logic [7:0]  ADDR_CFG2      = 8'h04,
   parameter logic [7:0]  ADDR_MODE      = 8'h08,
   parameter logic [7:0]  ADDR_EXT       = 8'h0C,
   parameter logic [7:0]  ADDR_CTRL      = 8'h10,
   parameter logic [7:0]  ADDR_REF       = 8'h14,
   parameter logic [31:0] CFG_WORD       = 32'h4A3C_2D10,
   parameter logic [31:0] CFG2_WORD      = 32'h8C5E_6208,
   parameter logic [31:0] EXT_DLL_WORD   = 32'h0000_0002,
   parameter logic [31:0] EXT_OCD_WORD   = 32'h0000_03C4,
   parameter logic [31:0] EXT_FINAL_WORD = 32'h0000_0044,
   parameter logic [15:0] MODE_CAS3      = 16'h0033,
   parameter logic [15:0] MODE_CAS4      = 16'h0043
) (
   input  step_t             step,
   input  logic              cas4,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data,
   output wait_cls_t         wcls
);

   // 7.8125 us refresh interval in cycles, truncated
   localparam int REF_CYCLES = (CLKS_PER_US * 78125) / 10000;
   localparam logic [15:0] REF_FIELD = REF_EN_BIT | 16'(REF_CYCLES);

   initial begin
      assert (REF_CYCLES > 0 && REF_CYCLES < 16384)
         else $error("refresh interval does not fit its field");
      assert (ADDR_W >= 8 && DATA_W >= 32)
         else $error("address or data width too narrow");
      assert ((CFG2_WORD & 32'(CKE_BIT)) == 32'd0)
         else $error("CFG2_WORD must leave the clock-enable bit clear");
   end

   logic [15:0] mode_fin;
   assign mode_fin = cas4 ? MODE_CAS4 : MODE_CAS3;

   function automatic logic [DATA_W-1:0] ctl(input logic [7:0] code);
      return DATA_W'(code);
   endfunction

   always_comb begin
      addr = ADDR_W'(ADDR_CTRL);
      data = '0;
      wcls = WC_CMD;
      case (step)
         ST_CFG: begin
            addr = ADDR_W'(ADDR_CFG);
            data = DATA_W'(CFG_WORD);
            wcls = WC_REG;
         end
         ST_CFG2: begin
            addr = ADDR_W'(ADDR_CFG2);
            data = DATA_W'(CFG2_WORD);
            wcls = WC_REG;
         end
         ST_CKE: begin
            addr = ADDR_W'(ADDR_CFG2);
            data = DATA_W'(CFG2_WORD | 32'(CKE_BIT));
            wcls = WC_REG;
         end
         ST_PRE_A, ST_PRE_B,
         ST_PRE_C, ST_PRE_D:  data = ctl(CMD_PALL);
         ST_EMR2:             data = ctl(CMD_EMR2);
         ST_EMR3:             data = ctl(CMD_EMR3);
         ST_DLL_WORD: begin
            addr = ADDR_W'(ADDR_EXT);
            data = DATA_W'(EXT_DLL_WORD);
            wcls = WC_REG;
         end
         ST_DLL_LOAD,
         ST_OCD_LOAD,
         ST_EXT_LOAD:         data = ctl(CMD_EMR);
         ST_MODE_INI: begin
            addr = ADDR_W'(ADDR_MODE);
            data = DATA_W'(mode_fin | MODE_INI_OR);
            wcls = WC_MODE;
         end
         ST_MR_A, ST_MR_B:    data = ctl(CMD_MR);
         ST_AREF_A, ST_AREF_B: data = ctl(CMD_AREF);
         ST_MODE_FIN: begin
            addr = ADDR_W'(ADDR_MODE);
            data = DATA_W'(mode_fin);
            wcls = WC_REG;
         end
         ST_OCD_WORD: begin
            addr = ADDR_W'(ADDR_EXT);
            data = DATA_W'(EXT_OCD_WORD);
            wcls = WC_REG;
         end
         ST_EXT_WORD: begin
            addr = ADDR_W'(ADDR_EXT);
            data = DATA_W'(EXT_FINAL_WORD);
            wcls = WC_REG;
         end
         default: begin
            addr = ADDR_W'(ADDR_REF);
            data = DATA_W'(REF_FIELD);
            wcls = WC_REG;
         end
      endcase
   end

endmodule

// File: rtl/ddr_init_step_walk.sv
module ddr_init_step_walk
   import ddr_init_pkg::*;
(
   input  step_t     cur,
   input  mem_kind_t kind,
   output step_t     nxt,
   output logic      last
);

   logic [NUM_STEPS-1:0] run_vec;

   // one enable per step, chosen by the memory kind
   for (genvar g = 0; g < NUM_STEPS; g++) begin : g_en
      assign run_vec[g] = step_enabled(step_t'(5'(g)), kind);
   end

   // nearest enabled step after the current one
   always_comb begin
      nxt  = cur;
      last = 1'b1;
      for (int j = NUM_STEPS - 1; j >= 0; j--) begin
         if (j > int'(cur) && run_vec[j]) begin
            nxt  = step_t'(5'(j));
            last = 1'b0;
         end
      end
   end

endmodule

// File: rtl/ddr_init_wait_timer.sv
module ddr_init_wait_timer
   import ddr_init_pkg::*;
#(
   parameter int CLKS_PER_US = 250,
   parameter int CMD_US      = 10,
   parameter int REG_US      = 100,
   parameter int MODE_US     = 1000
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      load,
   input  wait_cls_t cls,
   output logic      expired
);

   localparam int CMD_CYC  = CMD_US * CLKS_PER_US;
   localparam int REG_CYC  = REG_US * CLKS_PER_US;
   localparam int MODE_CYC = MODE_US * CLKS_PER_US;
   localparam int MAX_CYC  = (MODE_CYC > REG_CYC) ?
                             ((MODE_CYC > CMD_CYC) ? MODE_CYC : CMD_CYC) :
                             ((REG_CYC > CMD_CYC) ? REG_CYC : CMD_CYC);
   localparam int CNT_W    = $clog2(MAX_CYC + 1);

   initial begin
      assert (CLKS_PER_US >= 1)
         else $error("CLKS_PER_US must be at least one");
      assert (CMD_US >= 1 && REG_US >= 1 && MODE_US >= 1)
         else $error("every wait must be at least one microsecond");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] reload;

   always_comb begin
      case (cls)
         WC_MODE: reload = CNT_W'(MODE_CYC - 1);
         WC_REG:  reload = CNT_W'(REG_CYC - 1);
         default: reload = CNT_W'(CMD_CYC - 1);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= reload;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   // R3: the count falls by one per cycle between loads
   p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
   import ddr_init_pkg::*;
#(
   parameter int          ADDR_W         = 8,
   parameter int          DATA_W         = 32,
   parameter int          CLKS_PER_US    = 250,
   parameter int          CMD_US         = 10,
   parameter int          REG_US         = 100,
   parameter int          MODE_US        = 1000,
   parameter logic [7:0]  ADDR_CFG       = 8'h00,
   parameter logic [7:0]  ADDR_CFG2      = 8'h04,
   parameter logic [7:0]  ADDR_MODE      = 8'h08,
   parameter logic [7:0]  ADDR_EXT       = 8'h0C,
   parameter logic [7:0]  ADDR_CTRL      = 8'h10,
   parameter logic [7:0]  ADDR_REF       = 8'h14,
   parameter logic [31:0] CFG_WORD       = 32'h4A3C_2D10,
   parameter logic [31:0] CFG2_WORD      = 32'h8C5E_6208,
   parameter logic [31:0] EXT_DLL_WORD   = 32'h0000_0002,
   parameter logic [31:0] EXT_OCD_WORD   = 32'h0000_03C4,
   parameter logic [31:0] EXT_FINAL_WORD = 32'h0000_0044,
   parameter logic [15:0] MODE_CAS3      = 16'h0033,
   parameter logic [15:0] MODE_CAS4      = 16'h0043
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        mem_type,
   input  logic [2:0]        cas_lat,
   output logic              busy,
   output logic              done,
   output logic              reg_we,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata
);

   seq_state_t state;
   step_t      step_q;
   step_t      step_nxt;
   mem_kind_t  kind_q;
   logic       cas4_q;
   logic       step_last;
   logic       tmr_done;
   wait_cls_t  step_wcls;

   ddr_init_step_rom #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLKS_PER_US(CLKS_PER_US),
      .ADDR_CFG(ADDR_CFG), .ADDR_CFG2(ADDR_CFG2), .ADDR_MODE(ADDR_MODE),
      .ADDR_EXT(ADDR_EXT), .ADDR_CTRL(ADDR_CTRL), .ADDR_REF(ADDR_REF),
      .CFG_WORD(CFG_WORD), .CFG2_WORD(CFG2_WORD),
      .EXT_DLL_WORD(EXT_DLL_WORD), .EXT_OCD_WORD(EXT_OCD_WORD),
      .EXT_FINAL_WORD(EXT_FINAL_WORD),
      .MODE_CAS3(MODE_CAS3), .MODE_CAS4(MODE_CAS4)
   ) u_rom (
      .step (step_q),
      .cas4 (cas4_q),
      .addr (reg_addr),
      .data (reg_wdata),
      .wcls (step_wcls)
   );

   ddr_init_step_walk u_walk (
      .cur  (step_q),
      .kind (kind_q),
      .nxt  (step_nxt),
      .last (step_last)
   );

   ddr_init_wait_timer #(
      .CLKS_PER_US(CLKS_PER_US), .CMD_US(CMD_US),
      .REG_US(REG_US), .MODE_US(MODE_US)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (reg_we),
      .cls     (step_wcls),
      .expired (tmr_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SQ_IDLE;
         step_q <= ST_CFG;
         kind_q <= MEM_SDR;
         cas4_q <= 1'b0;
      end else begin
         case (state)
            SQ_IDLE: begin
               if (start) begin
                  kind_q <= mem_kind_t'(mem_type);
                  cas4_q <= (cas_lat == 3'd4);
                  step_q <= ST_CFG;
                  state  <= SQ_ISSUE;
               end
            end
            SQ_ISSUE: state <= SQ_WAIT;
            SQ_WAIT: begin
               if (tmr_done) begin
                  if (step_last) begin
                     state <= SQ_FIN;
                  end else begin
                     step_q <= step_nxt;
                     state  <= SQ_ISSUE;
                  end
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign reg_we = (state == SQ_ISSUE);
   assign busy   = (state == SQ_ISSUE) || (state == SQ_WAIT);
   assign done   = (state == SQ_FIN);

   // R3: a write strobe never lasts two cycles
   p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R2: writes only happen inside a busy window
   p_we_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> busy);

   // R2: done is a lone pulse with busy low
   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !reg_we));
   p_done_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3: control commands carry exactly one code bit
   p_ctrl_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(ADDR_CTRL)) |-> ($countones(reg_wdata) == 1));

   // R7: mode words only take the two latency values, with or without bit 8
   p_mode_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(ADDR_MODE)) |->
         (reg_wdata[7:0] == MODE_CAS3[7:0] || reg_wdata[7:0] == MODE_CAS4[7:0]));

   // R10: the captured kind holds steady while busy
   p_kind_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(kind_q));

   // R2: the end of busy is followed by done
   p_busy_to_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

endmodule

// File: tb/ddr_init_seq_bench.sv
`timescale 1ns/1ps
module ddr_init_seq_bench;

   localparam int CPU      = 2;
   localparam int A_CFG    = 8'h00;
   localparam int A_CFG2   = 8'h04;
   localparam int A_MODE   = 8'h08;
   localparam int A_EXT    = 8'h0C;
   localparam int A_CTRL   = 8'h10;
   localparam int A_REF    = 8'h14;
   localparam int W_CFG    = 32'h4A3C_2D10;
   localparam int W_CFG2   = 32'h8C5E_6208;
   localparam int W_DLL    = 32'h0000_0002;
   localparam int W_OCD    = 32'h0000_03C4;
   localparam int W_EXTF   = 32'h0000_0044;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  mem_type = 2'd0;
   logic [2:0]  cas_lat = 3'd3;
   logic        busy, done, reg_we;
   logic [7:0]  reg_addr;
   logic [31:0] reg_wdata;

   int checks = 0;
   int fails  = 0;

   int    e_addr[$];
   int    e_data[$];
   int    e_wait[$];
   string e_tag[$];

   always #2 clk = ~clk;

   ddr_init_seq #(
      .CLKS_PER_US(CPU)
   ) u_ddr_init_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .mem_type(mem_type), .cas_lat(cas_lat),
      .busy(busy), .done(done), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata)
   );

   task automatic push(input int a, input int d, input int us, input string t);
      e_addr.push_back(a);
      e_data.push_back(d);
      e_wait.push_back(us);
      e_tag.push_back(t);
   endtask

   task automatic build(input int kind, input int cas);
      int mw;
      e_addr.delete(); e_data.delete(); e_wait.delete(); e_tag.delete();
      mw = (cas == 4) ? 32'h43 : 32'h33;
      push(A_CFG,  W_CFG, 100, "R4");
      push(A_CFG2, W_CFG2, 100, "R4");
      push(A_CFG2, W_CFG2 | 32'h80, 100, "R4");
      push(A_CTRL, 32'h08, 10, "R4");
      push(A_CTRL, 32'h08, 10, "R4");
      if (kind == 2) begin
         push(A_CTRL, 32'h10, 10, "R5");
         push(A_CTRL, 32'h20, 10, "R5");
      end
      if (kind != 0) begin
         push(A_EXT,  W_DLL, 100, "R6");
         push(A_CTRL, 32'h02, 10, "R6");
      end
      push(A_MODE, mw | 32'h100, 1000, "R7");
      push(A_CTRL, 32'h01, 10, "R7");
      push(A_CTRL, 32'h08, 10, "R7");
      push(A_CTRL, 32'h08, 10, "R7");
      push(A_CTRL, 32'h04, 10, "R7");
      push(A_CTRL, 32'h04, 10, "R7");
      push(A_MODE, mw, 100, "R7");
      push(A_CTRL, 32'h01, 10, "R7");
      if (kind == 2) begin
         push(A_EXT,  W_OCD, 100, "R8");
         push(A_CTRL, 32'h02, 10, "R8");
         push(A_EXT,  W_EXTF, 100, "R8");
         push(A_CTRL, 32'h02, 10, "R8");
      end
      push(A_REF, 32'h4000 | ((CPU * 78125) / 10000), 100, "R9");
   endtask

   task automatic run(input int kind, input int cas, input bit disturb);
      int n, fin, nxt, k;
      bit exp_we;
      string sfx;
      build(kind, cas);
      n = e_addr.size();
      fin = 0;
      for (int i = 0; i < n; i++) fin += 1 + e_wait[i] * CPU;
      sfx = disturb ? "/R10" : "";
      @(negedge clk);
      mem_type = 2'(kind);
      cas_lat  = 3'(cas);
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
      nxt = 0;
      k = 0;
      for (int c = 0; c <= fin; c++) begin
         if (c > 0) @(negedge clk);
         exp_we = (k < n) && (c == nxt);
         checks++;
         if (reg_we !== exp_we) begin
            fails++;
            $display("FAIL R3%s: reg_we=%0d expected %0d at cycle %0d (kind %0d)",
                     sfx, reg_we, exp_we, c, kind);
         end
         if (exp_we) begin
            checks++;
            if (reg_addr !== 8'(e_addr[k]) || reg_wdata !== 32'(e_data[k])) begin
               fails++;
               $display("FAIL %s%s: write %0d got %h/%h expected %h/%h (kind %0d cas %0d)",
                        e_tag[k], sfx, k, reg_addr, reg_wdata,
                        8'(e_addr[k]), 32'(e_data[k]), kind, cas);
            end
            nxt += 1 + e_wait[k] * CPU;
            k++;
         end
         checks++;
         if (busy !== (c < fin) || done !== (c == fin)) begin
            fails++;
            $display("FAIL R2%s: busy/done=%0d/%0d expected %0d/%0d at cycle %0d",
                     sfx, busy, done, (c < fin), (c == fin), c);
         end
         if (disturb && c == 3) begin
            start    = 1'b1;
            mem_type = 2'(kind ^ 3);
            cas_lat  = (cas == 4) ? 3'd3 : 3'd4;
         end
         if (disturb && c == 4) start = 1'b0;
      end
      checks++;
      if (k != n) begin
         fails++;
         $display("FAIL R9: %0d writes seen expected %0d", k, n);
      end
      @(negedge clk);
      checks++;
      if (busy !== 1'b0 || done !== 1'b0 || reg_we !== 1'b0) begin
         fails++;
         $display("FAIL R2: after completion busy/done/we=%0d/%0d/%0d expected 0/0/0",
                  busy, done, reg_we);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (busy !== 1'b0 || done !== 1'b0 || reg_we !== 1'b0) begin
         fails++;
         $display("FAIL R1: in reset busy/done/we=%0d/%0d/%0d expected 0/0/0",
                  busy, done, reg_we);
      end
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      checks++;
      if (busy !== 1'b0 || done !== 1'b0 || reg_we !== 1'b0) begin
         fails++;
         $display("FAIL R1: idle busy/done/we=%0d/%0d/%0d expected 0/0/0",
                  busy, done, reg_we);
      end
      run(0, 3, 1'b0);   // SDRAM
      run(1, 4, 1'b0);   // DDR1
      run(2, 3, 1'b0);   // DDR2
      run(2, 4, 1'b1);   // DDR2, inputs disturbed mid-run (R10)
      run(3, 4, 1'b0);   // code 3 acts as DDR1 (R6)
      run(0, 7, 1'b1);   // other latency, disturbed
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

endmodule